// File: doc/BRIEF.md
# Pipelined SPI ADC Scan Sequencer

This block is the SPI master for a multichannel successive-approximation converter. The converter returns each result two frames after the command that asked for it. A one-cycle start pulse latches a channel enable mask. The block then sends one 16-bit command frame for each enabled channel, lowest index first. Two trailing frames follow, which only collect the last two results.

Every response word carries a 4-bit channel tag in its upper bits. The block pairs each response with the channel requested two frames earlier and compares the tag against that channel. It extracts the left-justified conversion value for the configured resolution. Each result is posted as a one-cycle strobe with channel, data and error flag. The serial clock divider and the minimum chip-select high time between frames are parameters.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, and whenever no scan is running, `cs_no` is high, `sclk_o` is low, `busy_o` is low and `res_valid_o` is low.
- R2: Each frame is 16 serial clocks long and most significant bit first. `sclk_o` idles low. MOSI changes only while `sclk_o` is low. MISO is sampled on the rising edge. Each half period of `sclk_o` lasts CLK_DIV system clocks.
- R3: A command word has bit 12 set (manual channel select) and bit 11 set (settings write). It carries the channel number in bits 10:7 and `range_dbl_i` in bit 6. All other bits are zero.
- R4: Command frames are sent only for channels whose mask bit is set, in ascending channel order.
- R5: A scan with K enabled channels takes exactly K+2 frames. The last two frames carry the all-zero word.
- R6: `cs_no` goes high after every frame and stays high for at least CS_GAP system clocks before the next frame. It stays high after the last frame of a scan.
- R7: The response shifted in during frame n+2 is attributed to the channel requested in frame n, and `res_ch_o` reports that channel. Results appear in ascending channel order, one per enabled channel.
- R8: `res_err_o` is high for a result exactly when bits 15:12 of its response differ from the expected channel.
- R9: `res_data_o` equals response bits 11 down to 12-RES_BITS, so the value is right-aligned.
- R10: `busy_o` rises one cycle after an accepted start with a non-empty mask and falls with the last result. Start pulses while busy are ignored.
- R11: `done_o` is a single-cycle pulse at the end of each scan. For a non-empty scan it coincides with the last `res_valid_o` strobe.
- R12: A start with an all-zero mask sends no frame, keeps `busy_o` low and pulses `done_o` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| ch_mask_i | input | N_CH | Channel enable mask, bit i enables channel i |
| range_dbl_i | input | 1 | Doubled input range setting placed in the commands |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial command data |
| miso_i | input | 1 | Serial response data |
| res_valid_o | output | 1 | Result strobe |
| res_ch_o | output | 4 | Channel of the posted result |
| res_data_o | output | RES_BITS | Extracted conversion value |
| res_err_o | output | 1 | Channel tag mismatch on this result |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | End-of-scan pulse |

## Verification
A result is due one system clock after the chip-select rise of the frame that carries it. For the channel requested in frame n, that frame is n+2. `done_o` for an empty mask is due one clock after the accepting edge. The bench models the converter at the pins, records every frame and every strobe at falling system clock edges, and compares the whole scan with values computed from the mask and a data seed. It checks that the final strobe and the done pulse fall in the same cycle.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int FRAME_W   = 16;
  localparam int TAG_W     = 4;
  localparam int DATA_W    = 12;
  localparam int RESP_LAG  = 2;
  localparam int BIT_MANUAL = 12;
  localparam int BIT_WRITE  = 11;
  localparam int BIT_CH_LSB = 7;
  localparam int BIT_RANGE  = 6;

  typedef struct packed {
    logic             v;
    logic [TAG_W-1:0] ch;
  } slot_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} seq_st_e;
  typedef enum logic [1:0] {FE_IDLE, FE_SHIFT, FE_GAP} fe_st_e;

  function automatic logic [FRAME_W-1:0] make_cmd(input logic [TAG_W-1:0] ch, input logic dbl);
    logic [FRAME_W-1:0] w;
    w = '0;
    w[BIT_MANUAL] = 1'b1;
    w[BIT_WRITE]  = 1'b1;
    w[BIT_CH_LSB +: TAG_W] = ch;
    w[BIT_RANGE]  = dbl;
    return w;
  endfunction
endpackage

// File: rtl/adc_spi_frame.sv
module adc_spi_frame
  import adc_scan_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CS_GAP  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic [FRAME_W-1:0] tx_i,
  output logic               ready_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] rx_o,
  output logic               sclk_o,
  output logic               cs_no,
  output logic               mosi_o,
  input  logic               miso_i
);
  localparam int DIV_W = $clog2(CLK_DIV) + 1;
  localparam int GAP_W = $clog2(CS_GAP) + 1;
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CS_GAP - 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(FRAME_W - 1);

  fe_st_e             st_q;
  logic [FRAME_W-1:0] tx_sr, rx_sr;
  logic [DIV_W-1:0]   div_q;
  logic [GAP_W-1:0]   gap_q;
  logic [CNT_W-1:0]   bit_q;
  logic               sclk_q, cs_nq, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FE_IDLE;
      tx_sr  <= '0;
      rx_sr  <= '0;
      div_q  <= '0;
      gap_q  <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b0;
      cs_nq  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        FE_IDLE: if (go_i) begin
          tx_sr <= tx_i;
          cs_nq <= 1'b0;
          div_q <= '0;
          bit_q <= '0;
          st_q  <= FE_SHIFT;
        end
        FE_SHIFT: begin
          if (div_q == DIV_LAST) begin
            div_q <= '0;
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              rx_sr  <= {rx_sr[FRAME_W-2:0], miso_i};
            end else begin
              sclk_q <= 1'b0;
              if (bit_q == BIT_LAST) begin
                cs_nq  <= 1'b1;
                done_q <= 1'b1;
                gap_q  <= '0;
                st_q   <= FE_GAP;
              end else begin
                bit_q <= bit_q + 1'b1;
                tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
              end
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        FE_GAP: begin
          if (gap_q == GAP_LAST) st_q <= FE_IDLE;
          else gap_q <= gap_q + 1'b1;
        end
        default: st_q <= FE_IDLE;
      endcase
    end
  end

  assign ready_o = (st_q == FE_IDLE);
  assign done_o  = done_q;
  assign rx_o    = rx_sr;
  assign sclk_o  = sclk_q;
  assign cs_no   = cs_nq;
  assign mosi_o  = !cs_nq && tx_sr[FRAME_W-1];
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int N_CH = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [N_CH-1:0]    mask_i,
  input  logic               range_dbl_i,
  input  logic               fe_ready_i,
  input  logic               fe_done_i,
  output logic               fe_go_o,
  output logic [FRAME_W-1:0] fe_tx_o,
  output slot_t              resp_slot_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int FL_W = $clog2(RESP_LAG + 1);

  seq_st_e          st_q;
  logic [N_CH-1:0]  pend_q;
  logic [FL_W-1:0]  flush_q;
  logic             dbl_q, done_q;
  slot_t            pipe_q [RESP_LAG+1];
  logic [TAG_W-1:0] nxt_ch;
  logic             has_pend;
  slot_t            new_slot;

  // lowest pending channel
  always_comb begin
    nxt_ch = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (pend_q[i]) nxt_ch = TAG_W'(i);
    end
  end

  assign has_pend = |pend_q;
  assign new_slot = has_pend ? '{v: 1'b1, ch: nxt_ch} : '{v: 1'b0, ch: '0};
  assign fe_go_o  = (st_q == SQ_ISSUE) && fe_ready_i;
  assign fe_tx_o  = has_pend ? make_cmd(nxt_ch, dbl_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SQ_IDLE;
      pend_q  <= '0;
      flush_q <= '0;
      dbl_q   <= 1'b0;
      done_q  <= 1'b0;
      for (int i = 0; i <= RESP_LAG; i++) pipe_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (start_i) begin
          if (mask_i == '0) begin
            done_q <= 1'b1;
          end else begin
            pend_q  <= mask_i;
            flush_q <= FL_W'(RESP_LAG);
            dbl_q   <= range_dbl_i;
            for (int i = 0; i <= RESP_LAG; i++) pipe_q[i] <= '0;
            st_q    <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: if (fe_go_o) begin
          pipe_q[0] <= new_slot;
          for (int i = 1; i <= RESP_LAG; i++) pipe_q[i] <= pipe_q[i-1];
          if (has_pend) pend_q <= pend_q & (pend_q - 1'b1);
          else flush_q <= flush_q - 1'b1;
          st_q <= SQ_WAIT;
        end
        SQ_WAIT: if (fe_done_i) begin
          if (!has_pend && flush_q == '0) begin
            st_q   <= SQ_IDLE;
            done_q <= 1'b1;
          end else begin
            st_q <= SQ_ISSUE;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign resp_slot_o = pipe_q[RESP_LAG];
  assign busy_o      = (st_q != SQ_IDLE);
  assign done_o      = done_q;
endmodule

// File: rtl/adc_result_unpack.sv
module adc_result_unpack
  import adc_scan_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                strobe_i,
  input  slot_t               slot_i,
  input  logic [FRAME_W-1:0]  rx_i,
  output logic                valid_o,
  output logic [TAG_W-1:0]    ch_o,
  output logic [RES_BITS-1:0] data_o,
  output logic                err_o
);
  logic [RES_BITS-1:0] ext;
  logic [TAG_W-1:0]    tag;

  assign tag = rx_i[FRAME_W-1 -: TAG_W];

  generate
    if (RES_BITS >= DATA_W) begin : g_full
      assign ext = RES_BITS'(rx_i[DATA_W-1:0]);
    end else begin : g_part
      assign ext = rx_i[DATA_W-1 -: RES_BITS];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ch_o    <= '0;
      data_o  <= '0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= strobe_i && slot_i.v;
      if (strobe_i && slot_i.v) begin
        ch_o   <= slot_i.ch;
        data_o <= ext;
        err_o  <= (tag != slot_i.ch);
      end
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int N_CH     = 16,
  parameter int RES_BITS = 12,
  parameter int CLK_DIV  = 4,
  parameter int CS_GAP   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [N_CH-1:0]     ch_mask_i,
  input  logic                range_dbl_i,
  output logic                sclk_o,
  output logic                cs_no,
  output logic                mosi_o,
  input  logic                miso_i,
  output logic                res_valid_o,
  output logic [TAG_W-1:0]    res_ch_o,
  output logic [RES_BITS-1:0] res_data_o,
  output logic                res_err_o,
  output logic                busy_o,
  output logic                done_o
);
  logic               fe_go, fe_ready, fe_done;
  logic [FRAME_W-1:0] fe_tx, fe_rx;
  slot_t              resp_slot;

  adc_scan_ctrl #(.N_CH(N_CH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mask_i      (ch_mask_i),
    .range_dbl_i (range_dbl_i),
    .fe_ready_i  (fe_ready),
    .fe_done_i   (fe_done),
    .fe_go_o     (fe_go),
    .fe_tx_o     (fe_tx),
    .resp_slot_o (resp_slot),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  adc_spi_frame #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (fe_go),
    .tx_i    (fe_tx),
    .ready_o (fe_ready),
    .done_o  (fe_done),
    .rx_o    (fe_rx),
    .sclk_o  (sclk_o),
    .cs_no   (cs_no),
    .mosi_o  (mosi_o),
    .miso_i  (miso_i)
  );

  adc_result_unpack #(.RES_BITS(RES_BITS)) u_unpack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (fe_done),
    .slot_i   (resp_slot),
    .rx_i     (fe_rx),
    .valid_o  (res_valid_o),
    .ch_o     (res_ch_o),
    .data_o   (res_data_o),
    .err_o    (res_err_o)
  );
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int N_CH = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [N_CH-1:0] ch_mask_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            res_valid_o,
  input logic            cs_no,
  input logic            sclk_o,
  input logic            mosi_o
);
  a_r1_idle_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);
  a_r2_sclk_low_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  a_r2_mosi_stable_sclk_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(mosi_o));
  a_r10_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && ch_mask_i != '0) |=> busy_o);
  a_r10_busy_fall_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_last_result_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(busy_o)) |-> res_valid_o);
  a_r12_empty_mask_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && ch_mask_i == '0) |=> (done_o && !busy_o));
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.N_CH(N_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .ch_mask_i   (ch_mask_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .res_valid_o (res_valid_o),
  .cs_no       (cs_no),
  .sclk_o      (sclk_o),
  .mosi_o      (mosi_o)
);

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;
  localparam int N_CH = 16;
  localparam int RES  = 10;
  localparam int DIV  = 2;
  localparam int GAP  = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dbl = 1'b0, miso = 1'b0;
  logic [N_CH-1:0] mask = '0;
  logic sclk, cs_n, mosi, rv, rerr, busy, done;
  logic [3:0] rch;
  logic [RES-1:0] rdata;

  always #5 clk = ~clk;

  adc_scan_seq #(.N_CH(N_CH), .RES_BITS(RES), .CLK_DIV(DIV), .CS_GAP(GAP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ch_mask_i(mask), .range_dbl_i(dbl),
    .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso),
    .res_valid_o(rv), .res_ch_o(rch), .res_data_o(rdata), .res_err_o(rerr),
    .busy_o(busy), .done_o(done));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // converter model at the pins
  logic [11:0] seed = 12'h000;
  logic [15:0] corrupt = '0;
  logic [15:0] s_tx = '0, s_rx = '0;
  logic [3:0]  h0 = '0, h1 = '0;
  logic        cs_prev = 1'b1, sclk_prev = 1'b0;
  int s_idx = 0, s_rises = 0, s_frames = 0, gap_cnt = 100, gap_min = 100, bad_rises = 0;
  logic [15:0] cmd_log [64];

  function automatic logic [11:0] val12(input logic [3:0] ch);
    return 12'(int'(ch) * 183 + int'(seed));
  endfunction

  always @(negedge clk) begin
    if (cs_prev && !cs_n) begin
      s_tx  = {h1 ^ (corrupt[h1] ? 4'h8 : 4'h0), val12(h1)};
      s_idx = 0;
      s_rises = 0;
      if (gap_cnt < gap_min) gap_min = gap_cnt;
    end else if (!cs_n && sclk_prev && !sclk) begin
      s_idx++;
    end
    if (!cs_n && !sclk_prev && sclk) begin
      s_rx = {s_rx[14:0], mosi};
      s_rises++;
    end
    if (!cs_prev && cs_n) begin
      if (s_rises != 16) bad_rises++;
      cmd_log[s_frames % 64] = s_rx;
      h1 = h0;
      h0 = s_rx[10:7];
      s_frames++;
      gap_cnt = 0;
    end
    if (cs_n) gap_cnt++;
    miso = (s_idx < 16) ? s_tx[15 - s_idx] : 1'b0;
    cs_prev = cs_n;
    sclk_prev = sclk;
  end

  // result monitor
  int got_n = 0, done_n = 0;
  logic [3:0] got_ch [20];
  logic [RES-1:0] got_d [20];
  logic got_e [20];
  logic done_with_valid = 1'b0, busy_at_done = 1'b0;

  always @(negedge clk) begin
    if (rv && got_n < 20) begin
      got_ch[got_n] = rch;
      got_d[got_n]  = rdata;
      got_e[got_n]  = rerr;
      got_n++;
    end
    if (done) begin
      done_n++;
      done_with_valid = rv;
      busy_at_done = busy;
    end
  end

  function automatic logic [15:0] exp_cmd(input int ch, input logic d);
    return 16'((1 << 12) | (1 << 11) | (ch << 7) | (int'(d) << 6));
  endfunction

  task automatic run_scan(input logic [15:0] m, input logic d, input logic [15:0] bad, input bit intrude);
    int k, f0, e, wait_c;
    int ech [16];
    bit ok;
    k = 0;
    for (int i = 0; i < 16; i++) if (m[i]) begin ech[k] = i; k++; end
    seed = 12'(m * 7 + 12'h135);
    corrupt = bad;
    got_n = 0; done_n = 0; gap_min = 100; bad_rises = 0;
    f0 = s_frames;
    @(negedge clk); start = 1'b1; mask = m; dbl = d;
    @(negedge clk); start = 1'b0; #1;
    if (k == 0) begin
      chk(done_n == 1 && !busy, "R12", "empty mask done/busy", done_n, 1);
      repeat (40) @(negedge clk);
      #1;
      chk(s_frames == f0 && done_n == 1, "R12", "empty mask frames", s_frames - f0, 0);
      return;
    end
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
    if (intrude) begin
      repeat (40) @(negedge clk);
      start = 1'b1; mask = 16'hFFFF; dbl = ~d;
      @(negedge clk); start = 1'b0;
    end
    wait_c = 0;
    while (done_n == 0 && wait_c < 20000) begin
      @(negedge clk); #1; wait_c++;
    end
    if (done_n == 0) begin
      chk(1'b0, "R11", "watchdog no done", 0, 1);
      return;
    end
    chk(done_with_valid && !busy_at_done, "R11", "last result with done, busy low", done_with_valid, 1);
    repeat (20) @(negedge clk);
    #1;
    chk(done_n == 1, "R11", "single done pulse", done_n, 1);
    chk(cs_n && !busy && !rv && !sclk, "R1", "idle after scan", cs_n, 1);
    chk(s_frames - f0 == k + 2, "R5", "frame count", s_frames - f0, k + 2);
    chk(bad_rises == 0, "R2", "frames with 16 clocks", bad_rises, 0);
    chk(gap_min >= GAP, "R6", "min chip select gap", gap_min, GAP);
    ok = 1'b1;
    for (int i = 0; i < k; i++) if (cmd_log[(f0 + i) % 64] != exp_cmd(ech[i], d)) ok = 1'b0;
    chk(ok, "R3", "command words", cmd_log[f0 % 64], exp_cmd(ech[0], d));
    chk(ok, "R4", "ascending enabled channels only", k, k);
    chk(cmd_log[(f0 + k) % 64] == 0 && cmd_log[(f0 + k + 1) % 64] == 0, "R5", "trailing frames zero",
        cmd_log[(f0 + k) % 64], 0);
    chk(got_n == k, "R7", "result count", got_n, k);
    for (int i = 0; i < k && i < got_n; i++) begin
      e = int'(val12(4'(ech[i])) >> (12 - RES));
      chk(got_ch[i] == 4'(ech[i]), "R7", "result channel", got_ch[i], ech[i]);
      chk(got_d[i] == RES'(e), "R9", "result data", got_d[i], e);
      chk(got_e[i] == bad[ech[i]], "R8", "tag error flag", got_e[i], bad[ech[i]]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "R1", "global watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    #1;
    chk(cs_n && !sclk && !busy && !rv && !done, "R1", "reset state", {cs_n, sclk, busy, rv}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_scan(16'h0000, 1'b0, '0, 1'b0);
    for (int c = 0; c < 16; c++) run_scan(16'(1 << c), 1'(c & 1), '0, 1'b0);
    run_scan(16'hFFFF, 1'b1, '0, 1'b0);
    run_scan(16'hA5A5, 1'b0, '0, 1'b0);
    run_scan(16'h8001, 1'b1, '0, 1'b0);
    run_scan(16'h0000, 1'b1, '0, 1'b0);
    lf = 16'hACE1;
    for (int n = 0; n < 8; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      run_scan(lf, lf[0], '0, 1'b0);
    end
    run_scan(16'h0F0F, 1'b0, 16'h0104, 1'b0);
    run_scan(16'h0013, 1'b1, '0, 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule